// File: doc/BRIEF.md
# Serial Command Character-Memory Writer

This block takes 16-bit command words shifted in over a three-wire serial port (active-low select, shift clock, data) and turns them into write cycles for a character memory of 16 lines by 32 columns and for a 16-entry per-line attribute memory. Both memories sit outside the block; it only drives their write ports. The top four bits of each word are the opcode. A write pointer made of a line and a column address selects where character entries land. Each character entry is built from two commands. An attribute half is staged first, and the code half then commits the full entry and moves the pointer forward.

A fill mode repeats one character entry from the pointer to the last address of the page, one address per system clock. A busy output is high while the fill runs, and memory commands that arrive during it are refused and recorded in a sticky error flag. Words whose opcode is 5 or above are not acted on here. They are passed unchanged, with a one-cycle strobe, to a configuration register bank downstream.

Top module: `osd_cmd_writer`

## Requirements
- R1: Serial data is sampled MSB first on rising shift-clock edges while select is low. A word is accepted when select rises after exactly 16 rising edges. With 15 or 17 edges the word is discarded and nothing is written or forwarded.
- R2: Opcode 0 (bits 15:12 = 0000) loads the line pointer from bits 11:8, the column pointer from bits 4:0 and the fill enable from bit 7. It produces no memory write.
- R3: Opcode 1 stores bits 11:0 as the staged character attributes and produces no memory write.
- R4: Opcode 2 with fill disabled writes one character entry at char_addr = {line, column}. The entry is char_wdata[23:12] = staged attributes and char_wdata[11:0] = bits 11:0 of the opcode-2 word.
- R5: After each non-fill opcode-2 write the pointer increments. Column 31 wraps to column 0 of the next line, and line 15 column 31 wraps to line 0 column 0.
- R6: Opcode 2 with fill enabled writes the same entry to every address from the pointer up to 511, one per clock in ascending order. busy is high in exactly those cycles. The pointer and the fill enable are left unchanged.
- R7: Opcodes 1 to 4 that arrive while busy is high are dropped and set lock_err. lock_err stays set until reset.
- R8: Opcode 3 stages 12 line-attribute bits. Opcode 4 writes line_wdata = {staged line bits, opcode-4 bits 11:0} at line_addr = line pointer. Both ignore the column and leave the pointer unchanged.
- R9: A word with opcode 5 to 15 appears unchanged on cfg_word with cfg_valid high for one clock, and causes no memory write.
- R10: Reset (synchronous, active low) clears every output, the pointer, the fill enable and both staging registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_sel_n | input | 1 | Serial select, active low (asynchronous) |
| ser_sck | input | 1 | Serial shift clock (asynchronous) |
| ser_sdi | input | 1 | Serial data (asynchronous) |
| char_we | output | 1 | Character memory write enable |
| char_addr | output | 9 | Character address {line, column} |
| char_wdata | output | 24 | Character entry {attributes, code half} |
| line_we | output | 1 | Line attribute memory write enable |
| line_addr | output | 4 | Line attribute address |
| line_wdata | output | 24 | Line attribute entry |
| busy | output | 1 | Fill in progress |
| lock_err | output | 1 | Sticky: a memory command was refused during a fill |
| cfg_valid | output | 1 | One-cycle strobe for a forwarded word |
| cfg_word | output | 16 | Forwarded configuration word |

## Verification
Properties check the fill on every cycle. While busy is high a write occurs in each cycle, the address steps by one, and the fill ends only after address 511. They also check that busy excludes line writes, that the error flag never clears, and that the forward strobe lasts one cycle and carries only high opcodes. Several behaviours show only in the bench's ordered scoreboard: how the two halves of an entry are combined, pointer wrap at line and page ends, column-independence of line writes, rejection of badly framed words, and the attribute staging that survives a refused command.

// File: rtl/osd_cmd_pkg.sv
// Shared constants and types for the serial command writer.
// Assumes the fixed 16-bit command word: opcode in bits 15:12,
// line 11:8, fill flag 7, column 4:0, payload 11:0.
package osd_cmd_pkg;
    localparam int WORD_W  = 16;
    localparam int OP_W    = 4;
    localparam int LINE_AW = 4;
    localparam int COL_AW  = 5;
    localparam int ATTR_W  = 12;
    localparam int ADDR_W  = LINE_AW + COL_AW;
    localparam int ENTRY_W = 2 * ATTR_W;

    typedef enum logic [2:0] {
        CMD_ADDR    = 3'd0,
        CMD_ATTR    = 3'd1,
        CMD_CHAR    = 3'd2,
        CMD_LATTR   = 3'd3,
        CMD_LCOMMIT = 3'd4,
        CMD_CFG     = 3'd5
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e            kind;
        logic [LINE_AW-1:0]   line;
        logic                 fill;
        logic [COL_AW-1:0]    col;
        logic [ATTR_W-1:0]    payload;
    } cmd_t;
endpackage

// File: rtl/ocw_serial_rx.sv
// Serial word receiver. Brings select, shift clock and data into the
// system clock domain with two-flop synchronizers, detects shift clock
// rising edges, shifts MSB first and emits a one-cycle strobe when
// select rises after exactly WORD_W edges.
// Assumes the shift clock half period spans at least three system clocks.
module ocw_serial_rx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sck,
    input  logic              sdi,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

    logic [1:0] sel_sync, sck_sync, sdi_sync;
    logic       sel_prev, sck_prev;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic sel_s, sck_s, sdi_s, sck_rise, sel_rise;

    assign sel_s    = sel_sync[1];
    assign sck_s    = sck_sync[1];
    assign sdi_s    = sdi_sync[1];
    assign sck_rise = sck_s && !sck_prev;
    assign sel_rise = sel_s && !sel_prev;

    // Synchronize the three asynchronous serial inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_sync <= 2'b11;
            sck_sync <= 2'b00;
            sdi_sync <= 2'b00;
            sel_prev <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            sel_sync <= {sel_sync[0], sel_n};
            sck_sync <= {sck_sync[0], sck};
            sdi_sync <= {sdi_sync[0], sdi};
            sel_prev <= sel_s;
            sck_prev <= sck_s;
        end
    end

    // Shift, count edges and validate the frame at select release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            cnt        <= '0;
            word_valid <= 1'b0;
            word       <= '0;
        end else begin
            word_valid <= 1'b0;
            if (sel_s) begin
                cnt <= '0;
                if (sel_rise && cnt == CNT_FULL) begin
                    word_valid <= 1'b1;
                    word       <= shreg;
                end
            end else if (sck_rise) begin
                shreg <= {shreg[WORD_W-2:0], sdi_s};
                if (cnt != CNT_OVER) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ocw_cmd_decode.sv
// Command decoder. Splits an accepted word into opcode class and
// fields for the write engine, and forwards opcodes 5..15 unchanged
// to the configuration bank with a registered one-cycle strobe.
module ocw_cmd_decode
    import osd_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    output logic              cmd_valid,
    output cmd_t              cmd,
    output logic              cfg_valid,
    output logic [WORD_W-1:0] cfg_word
);
    logic [OP_W-1:0] op;
    cmd_kind_e       kind;

    assign op = word[WORD_W-1 -: OP_W];

    // Map the opcode onto a command class.
    always_comb begin
        unique case (op)
            4'd0:    kind = CMD_ADDR;
            4'd1:    kind = CMD_ATTR;
            4'd2:    kind = CMD_CHAR;
            4'd3:    kind = CMD_LATTR;
            4'd4:    kind = CMD_LCOMMIT;
            default: kind = CMD_CFG;
        endcase
    end

    // Gather the word fields into the engine command.
    always_comb begin
        cmd.kind    = kind;
        cmd.line    = word[8 +: LINE_AW];
        cmd.fill    = word[7];
        cmd.col     = word[0 +: COL_AW];
        cmd.payload = word[0 +: ATTR_W];
        cmd_valid   = word_valid && (kind != CMD_CFG);
    end

    // Register forwarded configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_valid <= 1'b0;
            cfg_word  <= '0;
        end else begin
            cfg_valid <= word_valid && (kind == CMD_CFG);
            if (word_valid && kind == CMD_CFG) begin
                cfg_word <= word;
            end
        end
    end
endmodule

// File: rtl/ocw_write_engine.sv
// Write engine. Holds the {line, column} pointer, the fill enable and
// the two staging registers; commits character and line entries and
// runs the fill-to-end-of-page sequence at one address per clock.
// Assumes commands arrive at least two clocks apart.
module ocw_write_engine
    import osd_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  cmd_t               cmd,
    output logic               char_we,
    output logic [ADDR_W-1:0]  char_addr,
    output logic [ENTRY_W-1:0] char_wdata,
    output logic               line_we,
    output logic [LINE_AW-1:0] line_addr,
    output logic [ENTRY_W-1:0] line_wdata,
    output logic               busy,
    output logic               lock_err
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    logic [ADDR_W-1:0]  ptr;
    logic               fill_en;
    logic [ATTR_W-1:0]  char_stage;
    logic [ATTR_W-1:0]  line_stage;
    logic               fill_active;
    logic [ADDR_W-1:0]  fill_addr;
    logic               one_we;
    logic [ADDR_W-1:0]  one_addr;
    logic               mem_cmd;

    assign mem_cmd = cmd_valid && (cmd.kind != CMD_ADDR);

    // Pointer, staging and single-entry commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr        <= '0;
            fill_en    <= 1'b0;
            char_stage <= '0;
            line_stage <= '0;
            one_we     <= 1'b0;
            one_addr   <= '0;
            char_wdata <= '0;
            line_we    <= 1'b0;
            line_addr  <= '0;
            line_wdata <= '0;
        end else begin
            one_we  <= 1'b0;
            line_we <= 1'b0;
            if (cmd_valid && cmd.kind == CMD_ADDR) begin
                ptr     <= {cmd.line, cmd.col};
                fill_en <= cmd.fill;
            end else if (mem_cmd && !fill_active) begin
                unique case (cmd.kind)
                    CMD_ATTR:  char_stage <= cmd.payload;
                    CMD_LATTR: line_stage <= cmd.payload;
                    CMD_CHAR: begin
                        char_wdata <= {char_stage, cmd.payload};
                        if (!fill_en) begin
                            one_we   <= 1'b1;
                            one_addr <= ptr;
                            ptr      <= ptr + 1'b1;
                        end
                    end
                    CMD_LCOMMIT: begin
                        line_we    <= 1'b1;
                        line_addr  <= ptr[ADDR_W-1 -: LINE_AW];
                        line_wdata <= {line_stage, cmd.payload};
                    end
                    default: ;
                endcase
            end
        end
    end

    // Fill sequencer: one address per clock up to the page end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_active <= 1'b0;
            fill_addr   <= '0;
        end else if (fill_active) begin
            if (fill_addr == LAST_ADDR) begin
                fill_active <= 1'b0;
            end else begin
                fill_addr <= fill_addr + 1'b1;
            end
        end else if (cmd_valid && cmd.kind == CMD_CHAR && fill_en) begin
            fill_active <= 1'b1;
            fill_addr   <= ptr;
        end
    end

    // Sticky record of memory commands refused during a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_err <= 1'b0;
        end else if (mem_cmd && fill_active) begin
            lock_err <= 1'b1;
        end
    end

    // Character port sources: fill sequencer or single commit.
    always_comb begin
        char_we   = fill_active || one_we;
        char_addr = fill_active ? fill_addr : one_addr;
        busy      = fill_active;
    end
endmodule

// File: rtl/osd_cmd_writer.sv
// Top of the serial command character-memory writer: receiver,
// decoder and write engine in series. Memories are external.
module osd_cmd_writer
    import osd_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_sel_n,
    input  logic               ser_sck,
    input  logic               ser_sdi,
    output logic               char_we,
    output logic [ADDR_W-1:0]  char_addr,
    output logic [ENTRY_W-1:0] char_wdata,
    output logic               line_we,
    output logic [LINE_AW-1:0] line_addr,
    output logic [ENTRY_W-1:0] line_wdata,
    output logic               busy,
    output logic               lock_err,
    output logic               cfg_valid,
    output logic [WORD_W-1:0]  cfg_word
);
    logic              rx_valid;
    logic [WORD_W-1:0] rx_word;
    logic              cmd_valid;
    cmd_t              cmd;

    ocw_serial_rx #(.WORD_W(WORD_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (ser_sel_n),
        .sck        (ser_sck),
        .sdi        (ser_sdi),
        .word_valid (rx_valid),
        .word       (rx_word)
    );

    ocw_cmd_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (rx_valid),
        .word       (rx_word),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd),
        .cfg_valid  (cfg_valid),
        .cfg_word   (cfg_word)
    );

    ocw_write_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd),
        .char_we    (char_we),
        .char_addr  (char_addr),
        .char_wdata (char_wdata),
        .line_we    (line_we),
        .line_addr  (line_addr),
        .line_wdata (line_wdata),
        .busy       (busy),
        .lock_err   (lock_err)
    );
endmodule

// File: rtl/osd_cmd_writer_chk.sv
// Property checker for osd_cmd_writer, attached by bind.
module osd_cmd_writer_chk
    import osd_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              char_we,
    input logic [ADDR_W-1:0] char_addr,
    input logic              line_we,
    input logic              busy,
    input logic              lock_err,
    input logic              cfg_valid,
    input logic [OP_W-1:0]   cfg_op
);
    AST_FILL_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> char_we);                                            // R6
    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> char_addr == ADDR_W'($past(char_addr) + 1'b1)); // R6
    AST_FILL_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(char_addr) == {ADDR_W{1'b1}});          // R6
    AST_FILL_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !line_we);                                           // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |=> lock_err);                                       // R7
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(char_we && line_we));                                       // R8
    AST_CFG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> !cfg_valid);                                    // R9
    AST_CFG_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> cfg_op >= 4'd5);                                // R9
endmodule

bind osd_cmd_writer osd_cmd_writer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .char_we   (char_we),
    .char_addr (char_addr),
    .line_we   (line_we),
    .busy      (busy),
    .lock_err  (lock_err),
    .cfg_valid (cfg_valid),
    .cfg_op    (cfg_word[15:12])
);

// File: tb/osd_cmd_writer_test.sv
`timescale 1ns/1ps
module osd_cmd_writer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic        char_we, line_we, busy, lock_err, cfg_valid;
    logic [8:0]  char_addr;
    logic [23:0] char_wdata, line_wdata;
    logic [3:0]  line_addr;
    logic [15:0] cfg_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 char, 1 line, 2 cfg
        logic [8:0]  addr;
        logic [23:0] data;
        logic [15:0] cfg;
        bit          fill;
        string       tag;
    } exp_t;
    exp_t q[$];

    // bench model state, from the requirements
    logic [8:0]  m_ptr = '0;
    bit          m_fill = 0;
    logic [11:0] m_stage = '0;
    logic [11:0] m_lstage = '0;

    always #2 clk = ~clk;  // 250 MHz

    osd_cmd_writer uut (
        .clk(clk), .rst_n(rst_n), .ser_sel_n(sel_n), .ser_sck(sck), .ser_sdi(sdi),
        .char_we(char_we), .char_addr(char_addr), .char_wdata(char_wdata),
        .line_we(line_we), .line_addr(line_addr), .line_wdata(line_wdata),
        .busy(busy), .lock_err(lock_err), .cfg_valid(cfg_valid), .cfg_word(cfg_word)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic observe(input int kind, input logic [8:0] a, input logic [23:0] d, input logic [15:0] c);
        exp_t e;
        if (q.size() == 0) begin
            check(0, "unexpected output event", 32'(kind), 32'hFF);
            return;
        end
        e = q.pop_front();
        check(e.kind == kind, {e.tag, " kind"}, 32'(kind), 32'(e.kind));
        if (e.kind == kind && kind == 0) begin
            check(a == e.addr, {e.tag, " char_addr"}, 32'(a), 32'(e.addr));
            check(d == e.data, {e.tag, " char_wdata"}, 32'(d), 32'(e.data));
            check(busy == e.fill, {e.tag, " busy during write"}, 32'(busy), 32'(e.fill));
        end else if (e.kind == kind && kind == 1) begin
            check(a == e.addr, {e.tag, " line_addr"}, 32'(a), 32'(e.addr));
            check(d == e.data, {e.tag, " line_wdata"}, 32'(d), 32'(e.data));
        end else if (e.kind == kind) begin
            check(c == e.cfg, {e.tag, " cfg_word"}, 32'(c), 32'(e.cfg));
        end
    endtask

    // Monitor: compare every output event against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (char_we)   observe(0, char_addr, char_wdata, 16'h0);
            if (line_we)   observe(1, {5'd0, line_addr}, line_wdata, 16'h0);
            if (cfg_valid) observe(2, 9'd0, 24'd0, cfg_word);
            if (busy && !char_we) check(0, "R6 busy without write", 1, 0);
        end
    end

    task automatic push(input int kind, input logic [8:0] a, input logic [23:0] d,
                        input logic [15:0] c, input bit f, input string tag);
        exp_t e;
        e.kind = kind; e.addr = a; e.data = d; e.cfg = c; e.fill = f; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic send_bits(input logic [15:0] w, input int n);
        sel_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdi = (i < 16) ? w[15 - i] : 1'b0;
            repeat (4) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
        repeat (4) @(negedge clk);
        sel_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic do_addr(input logic [3:0] ln, input logic [4:0] col, input bit fl);
        m_ptr = {ln, col};
        m_fill = fl;
        send_bits({4'h0, ln, fl, 2'b00, col}, 16);
    endtask

    task automatic do_attr(input logic [11:0] a);
        m_stage = a;
        send_bits({4'h1, a}, 16);
    endtask

    task automatic do_char(input logic [11:0] c, input string tag);
        if (m_fill) begin
            for (int a = int'(m_ptr); a < 512; a++)
                push(0, 9'(a), {m_stage, c}, 16'h0, 1, tag);
        end else begin
            push(0, m_ptr, {m_stage, c}, 16'h0, 0, tag);
            m_ptr = m_ptr + 9'd1;
        end
        send_bits({4'h2, c}, 16);
    endtask

    task automatic do_lattr(input logic [11:0] a);
        m_lstage = a;
        send_bits({4'h3, a}, 16);
    endtask

    task automatic do_lcommit(input logic [11:0] a, input string tag);
        push(1, {5'd0, m_ptr[8:5]}, {m_lstage, a}, 16'h0, 0, tag);
        send_bits({4'h4, a}, 16);
    endtask

    task automatic do_cfg(input logic [15:0] w);
        push(2, 9'd0, 24'd0, w, 0, "R9 forward");
        send_bits(w, 16);
    endtask

    task automatic drain(input string tag);
        while (q.size() != 0 || busy) @(negedge clk);
        repeat (6) @(negedge clk);
        check(q.size() == 0, {tag, " queue empty"}, 32'(q.size()), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R10: reset state on every output
        check(!char_we && !line_we && !busy && !lock_err && !cfg_valid, "R10 reset strobes",
              {27'd0, char_we, line_we, busy, lock_err, cfg_valid}, 0);
        check(char_addr == 0 && char_wdata == 0, "R10 reset char port", {char_addr, 23'd0}, 0);
        check(line_wdata == 0 && cfg_word == 0, "R10 reset line/cfg", {line_wdata, 8'd0}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: pointer and staging start at zero
        do_char(12'h3C5, "R10 first write at 0 with zero attributes");
        drain("R10");

        // R2 R3 R4: address load, staging, commit
        do_addr(4'd2, 5'd3, 0);
        drain("R2 no write on address load");
        do_attr(12'hABC);
        drain("R3 no write on attribute stage");
        do_char(12'h123, "R4 commit");
        do_char(12'h456, "R5 increment");
        drain("R4");

        // R5: line wrap and page wrap
        do_addr(4'd3, 5'd31, 0);
        do_char(12'h0F1, "R5 last column");
        do_char(12'h0F2, "R5 wrap to next line");
        do_addr(4'd15, 5'd31, 0);
        do_attr(12'h5E7);
        do_char(12'hE01, "R5 last address");
        do_char(12'hE02, "R5 page wrap to 0");
        drain("R5");

        // R8: line attributes ignore column and keep the pointer
        do_addr(4'd5, 5'd17, 0);
        do_lattr(12'h5A5);
        do_lcommit(12'h0F0, "R8 line write");
        do_lattr(12'h777);
        do_lcommit(12'h999, "R8 second line write same line");
        do_char(12'h222, "R8 pointer not advanced by line commands");
        drain("R8");

        // R9: forwarded words
        do_cfg(16'h5123);
        do_cfg(16'hB00F);
        do_cfg(16'hFFFF);
        drain("R9");

        // R1: badly framed words are discarded
        send_bits(16'h7777, 15);
        send_bits(16'h7777, 17);
        send_bits(16'h2444, 15);
        drain("R1 discarded frames");
        do_cfg(16'h7777);
        drain("R1 good frame after bad ones");

        // R6: short fill, then fill again from same start (pointer kept)
        do_addr(4'd15, 5'd28, 1);
        do_attr(12'h1A2);
        do_char(12'hF00, "R6 fill");
        drain("R6 fill one");
        do_char(12'hF01, "R6 fill pointer unchanged");
        drain("R6 fill two");
        check(lock_err == 1'b0, "R7 no error without overlap", 32'(lock_err), 0);

        // R7: commands during a full-page fill are dropped
        do_addr(4'd0, 5'd0, 1);
        do_char(12'hD0D, "R6 full page fill");
        send_bits({4'h1, 12'h999}, 16);   // dropped
        send_bits({4'h4, 12'h888}, 16);   // dropped
        drain("R7 fill with refused commands");
        check(lock_err == 1'b1, "R7 error flag set", 32'(lock_err), 1);
        do_addr(4'd1, 5'd1, 0);
        do_char(12'h321, "R7 staged attributes untouched by refused command");
        drain("R7 after fill");
        check(lock_err == 1'b1, "R7 error flag sticky", 32'(lock_err), 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule